// File: doc/BRIEF.md
# Watchdog Timer with Sleep Wake-Up

This block is a watchdog that counts pulses of a slow, independent tick enable rather than cycles of the system clock, so it goes on counting while the processor it guards is stopped in sleep. The tick may pass straight to the watchdog counter, or software may route it through a power-of-two prescaler whose division is chosen by a 3-bit select. When the counter completes its base period, the block raises one of two single-cycle requests. If the system is running, it raises a reset request. If the system has entered sleep, it raises a wake-up request and leaves the sleep state.

Software keeps the watchdog quiet by pulsing a clear strobe. A sleep-entry strobe also restarts the count. Either strobe clears the prescaler as well when the prescaler is assigned to the watchdog. A static enable bit set to 0 stops the watchdog for good.

An active-low sticky flag tells software that a time-out has occurred. The flag reads 1 after power-on reset or a clear strobe. It drops to 0 on any expiry and stays at 0 until one of those two events.

Top module: `wdt_sleep_wake`

## Requirements
- R1: After `rst_n` is low, `reset_req_o` and `wake_req_o` are 0 and `no_tmo_o` is 1.
- R2: With the prescaler unassigned, the counter advances only on clocks where `tick_i` is 1. On the BASE_TICKS-th such tick after a restart, an expiry occurs and its request is high for exactly one clock, in the clock after that tick.
- R3: An expiry while awake raises only `reset_req_o`. After a `sleep_i` strobe, an expiry raises only `wake_req_o` and the block returns to the awake state, so the next expiry raises `reset_req_o`.
- R4: While `wd_en_i` is 0, neither request is ever raised, whatever `tick_i` does.
- R5: With `pre_assign_i`=1 and `pre_sel_i`=k (binary 0..7), the prescaler passes one tick in 2^k, so an expiry needs BASE_TICKS*2^k ticks. With `pre_assign_i`=0, the division is 1:1 whatever the value of `pre_sel_i`.
- R6: A `clear_i` or `sleep_i` strobe restarts the counter from zero, and the prescaler too when it is assigned. A strobe in the same clock as an expiring tick wins, and no request is raised.
- R7: `no_tmo_o` goes to 0 in the clock after an expiry. It stays 0 through sleep strobes and further ticks, and returns to 1 only in the clock after a `clear_i` strobe or on reset.
- R8: After an expiry the counter restarts from zero, so the next expiry needs another full period of passed ticks.
- R9: If `pre_sel_i` is lowered while the prescaler count already meets or exceeds the new division, the next tick passes at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| tick_i | input | 1 | Slow watchdog tick enable, one clock wide |
| wd_en_i | input | 1 | Static watchdog enable, 0 disables |
| pre_assign_i | input | 1 | 1 routes ticks through the prescaler |
| pre_sel_i | input | SEL_W | Prescaler division select, 2^value |
| clear_i | input | 1 | Clear-watchdog strobe |
| sleep_i | input | 1 | Sleep-entry strobe |
| reset_req_o | output | 1 | One-clock system reset request |
| wake_req_o | output | 1 | One-clock wake-up request |
| no_tmo_o | output | 1 | Sticky flag, 0 after a time-out |

## Verification
The bench builds the block with BASE_TICKS=5 and the default 3-bit select. This lets a full 1:128 expiry of 640 ticks run in a short simulation, while every division ratio keeps its full size. With a short base period, the bench can also line a clear or sleep strobe up with the exact expiring tick. It can also lower the division select part-way through a prescaled count, and repeat expiries back to back to show that the counter restarts.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Source of a raised request
  typedef enum logic [1:0] {
    EV_NONE  = 2'b00,
    EV_RESET = 2'b01,
    EV_WAKE  = 2'b10
  } wdt_event_e;

  // Width needed to hold values 0..n-1, never below 1
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned PW   = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             assigned_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             restart_i,
  input  logic             step_i,
  output logic             pass_o
);
  logic [PW-1:0] pcnt_q;
  logic [PW-1:0] limit;
  logic          at_limit;

  // Division 2^sel: the limit is the all-ones value below bit sel
  always_comb begin
    limit = '0;
    for (int b = 0; b < PW; b++) begin
      limit[b] = (b < int'(sel_i));
    end
  end

  // The >= compare lets a lowered select pass at once
  assign at_limit = (pcnt_q >= limit);
  assign pass_o   = step_i && !restart_i && (!assigned_i || at_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else if (assigned_i) begin
      if (restart_i) begin
        pcnt_q <= '0;
      end else if (step_i) begin
        pcnt_q <= at_limit ? '0 : pcnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned BASE_TICKS = 18,
  localparam int unsigned CW        = wdt_pkg::cnt_width(BASE_TICKS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic step_i,
  output logic expire_o
);
  localparam logic [CW-1:0] LAST = CW'(BASE_TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = step_i && !restart_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart_i || expire_o) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_event.sv
module wdt_event (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic clear_i,
  input  logic sleep_i,
  output logic reset_req_o,
  output logic wake_req_o,
  output logic no_tmo_o
);
  import wdt_pkg::*;

  logic       asleep_q;
  logic       flag_q;
  wdt_event_e ev_q;
  wdt_event_e ev_d;

  always_comb begin
    ev_d = EV_NONE;
    if (expire_i) begin
      ev_d = asleep_q ? EV_WAKE : EV_RESET;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep_q <= 1'b0;
      flag_q   <= 1'b1;
      ev_q     <= EV_NONE;
    end else begin
      ev_q <= ev_d;
      if (sleep_i) begin
        asleep_q <= 1'b1;
      end else if (expire_i) begin
        asleep_q <= 1'b0;
      end
      if (clear_i) begin
        flag_q <= 1'b1;
      end else if (expire_i) begin
        flag_q <= 1'b0;
      end
    end
  end

  assign reset_req_o = (ev_q == EV_RESET);
  assign wake_req_o  = (ev_q == EV_WAKE);
  assign no_tmo_o    = flag_q;
endmodule

// File: rtl/wdt_sleep_wake.sv
module wdt_sleep_wake #(
  parameter int unsigned BASE_TICKS = 18,
  parameter int unsigned SEL_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wd_en_i,
  input  logic             pre_assign_i,
  input  logic [SEL_W-1:0] pre_sel_i,
  input  logic             clear_i,
  input  logic             sleep_i,
  output logic             reset_req_o,
  output logic             wake_req_o,
  output logic             no_tmo_o
);
  logic restart;
  logic step;
  logic pass;
  logic expire;

  assign restart = clear_i || sleep_i;
  assign step    = wd_en_i && tick_i;

  wdt_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk        (clk),
    .rst_n      (rst_n),
    .assigned_i (pre_assign_i),
    .sel_i      (pre_sel_i),
    .restart_i  (restart),
    .step_i     (step),
    .pass_o     (pass)
  );

  wdt_counter #(.BASE_TICKS(BASE_TICKS)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart),
    .step_i    (pass),
    .expire_o  (expire)
  );

  wdt_event u_evt (
    .clk         (clk),
    .rst_n       (rst_n),
    .expire_i    (expire),
    .clear_i     (clear_i),
    .sleep_i     (sleep_i),
    .reset_req_o (reset_req_o),
    .wake_req_o  (wake_req_o),
    .no_tmo_o    (no_tmo_o)
  );
endmodule

// File: rtl/wdt_sleep_wake_chk.sv
module wdt_sleep_wake_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_i,
  input logic wd_en_i,
  input logic clear_i,
  input logic sleep_i,
  input logic reset_req_o,
  input logic wake_req_o,
  input logic no_tmo_o
);
  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    !(reset_req_o && wake_req_o)); // R3
  AST_RESET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |=> !reset_req_o); // R2
  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req_o |=> !wake_req_o); // R3
  AST_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick_i) |-> (!reset_req_o && !wake_req_o)); // R2
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wd_en_i) |-> (!reset_req_o && !wake_req_o)); // R4
  AST_STROBE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear_i || sleep_i) |-> (!reset_req_o && !wake_req_o)); // R6
  AST_FLAG_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_req_o || wake_req_o) |-> !no_tmo_o); // R7
  AST_FLAG_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear_i) |-> no_tmo_o); // R7
endmodule

bind wdt_sleep_wake wdt_sleep_wake_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_i      (tick_i),
  .wd_en_i     (wd_en_i),
  .clear_i     (clear_i),
  .sleep_i     (sleep_i),
  .reset_req_o (reset_req_o),
  .wake_req_o  (wake_req_o),
  .no_tmo_o    (no_tmo_o)
);

// File: tb/wdt_sleep_wake_tb.sv
module wdt_sleep_wake_tb;
  localparam int N     = 5;
  localparam int SEL_W = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick_i = 1'b0;
  logic             wd_en_i = 1'b0;
  logic             pre_assign_i = 1'b0;
  logic [SEL_W-1:0] pre_sel_i = '0;
  logic             clear_i = 1'b0;
  logic             sleep_i = 1'b0;
  logic             reset_req_o;
  logic             wake_req_o;
  logic             no_tmo_o;

  int vectors = 0;
  int fails = 0;
  int n_rr = 0;
  int n_wr = 0;
  string phase = "R1";
  bit done = 1'b0;

  // Reference model state
  int  m_p = 0;
  int  m_c = 0;
  bit  m_sleep = 1'b0;
  bit  m_flag = 1'b1;
  bit  e_rr = 1'b0;
  bit  e_wr = 1'b0;

  always #2 clk = ~clk;

  wdt_sleep_wake #(.BASE_TICKS(N), .SEL_W(SEL_W)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .wd_en_i      (wd_en_i),
    .pre_assign_i (pre_assign_i),
    .pre_sel_i    (pre_sel_i),
    .clear_i      (clear_i),
    .sleep_i      (sleep_i),
    .reset_req_o  (reset_req_o),
    .wake_req_o   (wake_req_o),
    .no_tmo_o     (no_tmo_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_p = 0; m_c = 0; m_sleep = 0; m_flag = 1; e_rr = 0; e_wr = 0;
    end else begin
      bit ex;
      ex = 0;
      if (clear_i || sleep_i) begin
        m_c = 0;
        if (pre_assign_i) m_p = 0;
      end else if (wd_en_i && tick_i) begin
        bit pass;
        pass = 1;
        if (pre_assign_i) begin
          if (m_p + 1 >= (1 << pre_sel_i)) m_p = 0;
          else begin m_p = m_p + 1; pass = 0; end
        end
        if (pass) begin
          m_c = m_c + 1;
          if (m_c == N) begin ex = 1; m_c = 0; end
        end
      end
      e_rr = ex && !m_sleep;
      e_wr = ex && m_sleep;
      if (sleep_i) m_sleep = 1;
      else if (ex) m_sleep = 0;
      if (clear_i) m_flag = 1;
      else if (ex) m_flag = 0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model, and request counting
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(phase, "reset_req_o", int'(reset_req_o), int'(e_rr));
      chk(phase, "wake_req_o", int'(wake_req_o), int'(e_wr));
      chk(phase, "no_tmo_o", int'(no_tmo_o), int'(m_flag));
      if (reset_req_o) n_rr++;
      if (wake_req_o) n_wr++;
    end
  end

  task automatic ticks(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
    end
  endtask

  task automatic strobe_clear();
    @(negedge clk) clear_i = 1'b1;
    @(negedge clk) clear_i = 1'b0;
  endtask

  task automatic strobe_sleep();
    @(negedge clk) sleep_i = 1'b1;
    @(negedge clk) sleep_i = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int base_rr;
    int base_wr;
    repeat (3) @(negedge clk);
    chk("R1", "reset_req_o in reset", int'(reset_req_o), 0);
    chk("R1", "wake_req_o in reset", int'(wake_req_o), 0);
    chk("R1", "no_tmo_o in reset", int'(no_tmo_o), 1);
    rst_n = 1'b1;
    wd_en_i = 1'b1;

    // R2: period of N ticks, unprescaled
    phase = "R2";
    ticks(N - 1);
    chk("R2", "no request before period", n_rr, 0);
    ticks(1);
    @(negedge clk);
    chk("R2", "reset request after period", n_rr, 1);
    chk("R7", "flag low after expiry", int'(no_tmo_o), 0);

    // R8: restart after expiry
    phase = "R8";
    ticks(N);
    @(negedge clk);
    chk("R8", "second expiry after full period", n_rr, 2);

    // R7: clear restores flag; sleep keeps it low
    phase = "R7";
    strobe_clear();
    chk("R7", "flag high after clear", int'(no_tmo_o), 1);

    // R3: sleep expiry wakes, then awake expiry resets
    phase = "R3";
    base_rr = n_rr;
    strobe_sleep();
    ticks(N);
    @(negedge clk);
    chk("R3", "wake request while asleep", n_wr, 1);
    chk("R3", "no reset request while asleep", n_rr, base_rr);
    strobe_sleep();
    chk("R7", "flag stays low after sleep strobe", int'(no_tmo_o), 0);
    ticks(N);
    ticks(N);
    @(negedge clk);
    chk("R3", "wake then reset", n_rr, base_rr + 1);
    chk("R3", "one wake per sleep", n_wr, 2);

    // R4: disabled never expires
    phase = "R4";
    base_rr = n_rr; base_wr = n_wr;
    wd_en_i = 1'b0;
    ticks(4 * N);
    chk("R4", "no reset when disabled", n_rr, base_rr);
    chk("R4", "no wake when disabled", n_wr, base_wr);
    wd_en_i = 1'b1;

    // R5: prescaler ratios
    phase = "R5";
    strobe_clear();
    pre_assign_i = 1'b1; pre_sel_i = 3'd2;
    base_rr = n_rr;
    ticks(N * 4 - 1);
    chk("R5", "no expiry before 1:4 period", n_rr, base_rr);
    ticks(1);
    @(negedge clk);
    chk("R5", "expiry at 1:4 period", n_rr, base_rr + 1);
    pre_assign_i = 1'b0; pre_sel_i = 3'd7;
    strobe_clear();
    ticks(N);
    @(negedge clk);
    chk("R5", "unassigned is 1:1", n_rr, base_rr + 2);
    pre_assign_i = 1'b1;
    strobe_clear();
    ticks(N * 128 - 1);
    chk("R5", "no expiry before 1:128 period", n_rr, base_rr + 2);
    ticks(1);
    @(negedge clk);
    chk("R5", "expiry at 1:128 period", n_rr, base_rr + 3);

    // R6: strobes restart and win over expiry
    phase = "R6";
    pre_assign_i = 1'b0;
    strobe_clear();
    base_rr = n_rr; base_wr = n_wr;
    ticks(N - 1);
    strobe_clear();
    ticks(N - 1);
    chk("R6", "clear restarts count", n_rr, base_rr);
    @(negedge clk) begin tick_i = 1'b1; clear_i = 1'b1; end
    @(negedge clk) begin tick_i = 1'b0; clear_i = 1'b0; end
    chk("R6", "clear beats expiring tick", n_rr, base_rr);
    ticks(N - 1);
    @(negedge clk) begin tick_i = 1'b1; sleep_i = 1'b1; end
    @(negedge clk) begin tick_i = 1'b0; sleep_i = 1'b0; end
    chk("R6", "sleep beats expiring tick", n_rr + n_wr, base_rr + base_wr);
    ticks(N);
    @(negedge clk);
    chk("R6", "full period after sleep strobe", n_wr, base_wr + 1);

    // R9: lowering the select mid-count
    phase = "R9";
    strobe_clear();
    pre_assign_i = 1'b1; pre_sel_i = 3'd3;
    strobe_clear();
    base_rr = n_rr;
    ticks(6);
    @(negedge clk) pre_sel_i = 3'd1;
    ticks(8);
    chk("R9", "no expiry one tick early", n_rr, base_rr);
    ticks(1);
    @(negedge clk);
    chk("R9", "lowered select passes at once", n_rr, base_rr + 1);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule